// File: doc/BRIEF.md
# Segment Register Load Unit

This block updates one entry of a small segment-register cache from a 16-bit selector. When protection is enabled and the virtual-8086 flag is clear, it checks the selector's index against the global descriptor table limit. It then fetches the 8-byte descriptor over a one-beat read port and applies the type, privilege and presence rules. If every check passes, it writes the base, limit and attribute fields into the entry. If a check fails, it reports a fault code and leaves the entry untouched. The stack segment entry gets a stricter set of rules than the other entries. It also gets its own fault code when its descriptor is marked absent.

When protection is disabled, or the virtual-8086 flag is set, no descriptor is read. The selector is stored, and the base becomes the selector multiplied by sixteen. The limit and attributes already in the entry stay as they are. Requests are taken one at a time while `req_ready` is high. Each request ends with a single-cycle `done` pulse, which carries the fault outcome with it. A combinational read port lets the surrounding core observe any cache entry.

Top module: `seg_load_unit`

## Requirements
- R1: When `prot_en` is 0 or `v86` is 1, an accepted request stores the selector and sets the base to `{12'b0, sel, 4'b0000}`. The entry's limit and attributes are kept. No read is issued. `done` pulses with `fault` 0 in the cycle after acceptance.
- R2: In protected mode, a request whose last descriptor byte offset `{sel[15:3], 3'b111}` exceeds `gdt_limit` faults with the general-protection code. No read is issued, and `done` pulses in the cycle after acceptance.
- R3: A stack-segment load whose selector index is 0 faults with the general-protection code before any read.
- R4: A stack-segment load faults with the general-protection code if the descriptor's executable bit (bit 43) is set or its writable bit (bit 41) is clear.
- R5: A stack-segment load faults with the general-protection code unless the selector's requested privilege `sel[1:0]` equals both `cpl` and the descriptor privilege (bits 46:45).
- R6: A load into any other entry faults with the general-protection code when both the requested privilege and `cpl` are numerically greater than the descriptor privilege.
- R7: A descriptor whose present bit (bit 47) is clear faults with the stack code for the stack-segment entry (index `SS_IDX`, default 2) and with the not-present code for any other entry.
- R8: The checks are applied in this order: index range, null, type, privilege, presence. Only the first failure is reported, and a faulting load changes no cache field.
- R9: On success the selector is stored, and the base is descriptor bits 63:56 above bits 39:16.
- R10: On success the limit is bits 51:48 above bits 15:0. When the granularity bit (bit 55) is set, this value is shifted left by 12 and the low 12 bits are filled with ones.
- R11: In protected mode the read address is `gdt_base + 8*sel[15:3]`. `mem_rd_req` holds with a stable address until `mem_rd_valid`, and `done` pulses in the cycle after the data beat.
- R12: `fault_vec` is 0 with no fault, 1 for general protection, 2 for stack fault and 3 for not present. It is non-zero only together with `fault`, and `fault` is high only together with `done`.
- R13: `rd_attr` packs, from bit 9 down: granularity (55), default size (54), present (47), privilege (46:45), descriptor class (44), executable (43), direction (42), writable (41), accessed (40). After reset every entry holds selector 0, base 0, limit 0x0000FFFF and attributes 0x082.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_sel | input | 16 | Selector to load |
| req_seg | input | IDX_W | Target cache entry |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 flag |
| gdt_base | input | ADDR_W | Descriptor table base address |
| gdt_limit | input | 16 | Descriptor table byte limit |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | ADDR_W | Descriptor read address |
| mem_rd_valid | input | 1 | Read data beat |
| mem_rd_data | input | 64 | Descriptor contents |
| done | output | 1 | Load finished (pulse) |
| fault | output | 1 | Load faulted (with done) |
| fault_vec | output | 2 | Fault code |
| rd_idx | input | IDX_W | Cache entry to observe |
| rd_sel | output | 16 | Stored selector |
| rd_base | output | 32 | Stored base |
| rd_limit | output | 32 | Stored limit |
| rd_attr | output | 10 | Stored attributes |

## Verification
The properties assume that `mem_rd_valid` is asserted only while `mem_rd_req` is high. They also assume that `gdt_limit`, `prot_en` and `v86` describe the request in the cycle it is accepted. The fault-preservation property assumes that `rd_idx` does not change in the cycle before it is evaluated. The stimulus keeps to these rules. Its memory model answers only a pending read, one cycle after the request appears. Every request field and `rd_idx` change only at falling edges while the unit is idle. The sweeps cover every privilege pairing across descriptors that mix types, privileges, presence and granularity.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    localparam int DESC_W = 64;
    localparam int SEL_W  = 16;
    localparam int BASE_W = 32;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_SS   = 2'd2,
        FLT_NP   = 2'd3
    } flt_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

    typedef struct packed {
        logic       gran;
        logic       size;
        logic       present;
        logic [1:0] dpl;
        logic       sys;
        logic       exec;
        logic       dc;
        logic       rw;
        logic       acc;
    } seg_attr_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [BASE_W-1:0] base;
        logic [BASE_W-1:0] limit;
        seg_attr_t         attr;
    } seg_entry_t;

    localparam seg_entry_t ENTRY_RESET = '{
        sel:   '0,
        base:  '0,
        limit: 32'h0000_FFFF,
        attr:  10'h082
    };

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_load_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output logic [BASE_W-1:0] base,
    output logic [BASE_W-1:0] limit,
    output seg_attr_t         attr
);
    logic [19:0] raw_limit;
    logic        unused_desc;

    assign unused_desc = ^desc[53:52];

    always_comb begin
        base      = {desc[63:56], desc[39:16]};
        raw_limit = {desc[51:48], desc[15:0]};
        attr      = '{gran:    desc[55],
                      size:    desc[54],
                      present: desc[47],
                      dpl:     desc[46:45],
                      sys:     desc[44],
                      exec:    desc[43],
                      dc:      desc[42],
                      rw:      desc[41],
                      acc:     desc[40]};
        if (attr.gran) begin
            limit = {raw_limit, 12'hFFF};
        end else begin
            limit = {12'h000, raw_limit};
        end
    end

endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_load_pkg::*;
(
    input  logic [12:0] pre_index,
    input  logic        pre_is_ss,
    input  logic [15:0] gdt_limit,
    input  logic [1:0]  post_rpl,
    input  logic [1:0]  post_cpl,
    input  logic        post_is_ss,
    input  seg_attr_t   attr,
    output flt_e        pre_flt,
    output flt_e        post_flt
);
    logic [15:0] last_byte;
    logic        range_bad;
    logic        null_bad;
    logic        type_bad;
    logic        priv_bad;

    always_comb begin
        last_byte = {pre_index, 3'b111};
        range_bad = last_byte > gdt_limit;
        null_bad  = pre_is_ss && (pre_index == 13'd0);

        if (range_bad || null_bad) begin
            pre_flt = FLT_GP;
        end else begin
            pre_flt = FLT_NONE;
        end

        type_bad = post_is_ss && (attr.exec || !attr.rw);
        if (post_is_ss) begin
            priv_bad = (post_rpl != post_cpl) || (post_rpl != attr.dpl);
        end else begin
            priv_bad = (post_rpl > attr.dpl) && (post_cpl > attr.dpl);
        end

        if (type_bad || priv_bad) begin
            post_flt = FLT_GP;
        end else if (!attr.present) begin
            post_flt = post_is_ss ? FLT_SS : FLT_NP;
        end else begin
            post_flt = FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_cache.sv
module seg_cache
    import seg_load_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_full,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);
    seg_entry_t [NUM_SEGS-1:0] ent_all;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
        seg_entry_t ent_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= ENTRY_RESET;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q.sel  <= wr_entry.sel;
                ent_q.base <= wr_entry.base;
                if (wr_full) begin
                    ent_q.limit <= wr_entry.limit;
                    ent_q.attr  <= wr_entry.attr;
                end
            end
        end

        assign ent_all[g] = ent_q;
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_entry = ent_all[i];
            end
        end
    end

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_load_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    parameter int SS_IDX   = 2,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_sel,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [1:0]        cpl,
    input  logic              prot_en,
    input  logic              v86,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [15:0]       gdt_limit,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_vec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [15:0]       rd_sel,
    output logic [31:0]       rd_base,
    output logic [31:0]       rd_limit,
    output logic [9:0]        rd_attr
);
    localparam logic [IDX_W-1:0] SS_SLOT = IDX_W'(SS_IDX);

    typedef struct packed {
        st_e              st;
        logic [15:0]      sel;
        logic [IDX_W-1:0] seg;
        logic [1:0]       cpl;
        logic             done;
        logic             fault;
        flt_e             fvec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BASE_W-1:0] dec_base;
    logic [BASE_W-1:0] dec_limit;
    seg_attr_t         dec_attr;
    flt_e              pre_flt;
    flt_e              post_flt;

    logic              wr_en;
    logic              wr_full;
    logic [IDX_W-1:0]  wr_idx;
    seg_entry_t        wr_entry;
    seg_entry_t        rd_entry;

    seg_desc_decode u_decode (
        .desc  (mem_rd_data),
        .base  (dec_base),
        .limit (dec_limit),
        .attr  (dec_attr)
    );

    seg_rule_check u_rules (
        .pre_index  (req_sel[15:3]),
        .pre_is_ss  (req_seg == SS_SLOT),
        .gdt_limit  (gdt_limit),
        .post_rpl   (ctl_q.sel[1:0]),
        .post_cpl   (ctl_q.cpl),
        .post_is_ss (ctl_q.seg == SS_SLOT),
        .attr       (dec_attr),
        .pre_flt    (pre_flt),
        .post_flt   (post_flt)
    );

    seg_cache #(
        .NUM_SEGS (NUM_SEGS),
        .IDX_W    (IDX_W)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_full  (wr_full),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.fault = 1'b0;
        ctl_d.fvec  = FLT_NONE;
        wr_en       = 1'b0;
        wr_full     = 1'b0;
        wr_idx      = ctl_q.seg;
        wr_entry    = '{sel: ctl_q.sel, base: dec_base,
                        limit: dec_limit, attr: dec_attr};

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.sel = req_sel;
                    ctl_d.seg = req_seg;
                    ctl_d.cpl = cpl;
                    if (!prot_en || v86) begin
                        wr_en          = 1'b1;
                        wr_idx         = req_seg;
                        wr_entry.sel   = req_sel;
                        wr_entry.base  = {12'h000, req_sel, 4'h0};
                        ctl_d.done     = 1'b1;
                    end else if (pre_flt != FLT_NONE) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.fault = 1'b1;
                        ctl_d.fvec  = pre_flt;
                    end else begin
                        ctl_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_valid) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    if (post_flt != FLT_NONE) begin
                        ctl_d.fault = 1'b1;
                        ctl_d.fvec  = post_flt;
                    end else begin
                        wr_en   = 1'b1;
                        wr_full = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, sel: '0, seg: '0, cpl: '0,
                       done: 1'b0, fault: 1'b0, fvec: FLT_NONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign mem_rd_req  = (ctl_q.st == ST_FETCH);
    assign mem_rd_addr = gdt_base + ADDR_W'({ctl_q.sel[15:3], 3'b000});
    assign done        = ctl_q.done;
    assign fault       = ctl_q.fault;
    assign fault_vec   = ctl_q.fvec;
    assign rd_sel      = rd_entry.sel;
    assign rd_base     = rd_entry.base;
    assign rd_limit    = rd_entry.limit;
    assign rd_attr     = rd_entry.attr;

endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [15:0]       req_sel,
    input logic              prot_en,
    input logic              v86,
    input logic [15:0]       gdt_limit,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              done,
    input logic              fault,
    input logic [1:0]        fault_vec,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [31:0]       rd_base,
    input logic [31:0]       rd_limit
);
    logic accept;
    logic out_of_table;

    assign accept       = req_valid && req_ready;
    assign out_of_table = {req_sel[15:3], 3'b111} > gdt_limit;

    AST_REAL_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (!prot_en || v86) |=> done && !fault && !mem_rd_req); // R1

    AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && prot_en && !v86 && out_of_table
        |=> done && fault && (fault_vec == 2'd1) && !mem_rd_req); // R2

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done && (fault_vec != 2'd0)); // R12

    AST_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_vec == 2'd0)); // R12

    AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault && $stable(rd_idx) |-> $stable(rd_base) && $stable(rd_limit)); // R8

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr)); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready); // R11

endmodule

bind seg_load_unit seg_load_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_seg_load_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_sel      (req_sel),
    .prot_en      (prot_en),
    .v86          (v86),
    .gdt_limit    (gdt_limit),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .done         (done),
    .fault        (fault),
    .fault_vec    (fault_vec),
    .rd_idx       (rd_idx),
    .rd_base      (rd_base),
    .rd_limit     (rd_limit)
);

// File: tb/seg_load_unit_bench.sv
module seg_load_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG       = 6;
    localparam int SSI        = 2;
    localparam logic [31:0] GDT_BASE = 32'h0001_0000;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [2:0]  req_seg = '0;
    logic [1:0]  cpl = '0;
    logic        prot_en = 1'b0;
    logic        v86 = 1'b0;
    logic [31:0] gdt_base = GDT_BASE;
    logic [15:0] gdt_limit = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        done;
    logic        fault;
    logic [1:0]  fault_vec;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_sel;
    logic [31:0] rd_base;
    logic [31:0] rd_limit;
    logic [9:0]  rd_attr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int fetch_cnt = 0;
    int cur_idx   = 0;

    logic [15:0] m_sel   [NSEG];
    logic [31:0] m_base  [NSEG];
    logic [31:0] m_limit [NSEG];
    logic [9:0]  m_attr  [NSEG];

    seg_load_unit u_seg_load_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_seg(req_seg), .cpl(cpl), .prot_en(prot_en),
        .v86(v86), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .fault(fault), .fault_vec(fault_vec), .rd_idx(rd_idx),
        .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] gen_desc(input int i);
        logic [7:0]  ib;
        logic [23:0] blo;
        logic [15:0] llo;
        logic        p, gr;
        ib  = i[7:0];
        blo = 24'h012300 + 24'(i * 24'h1111);
        llo = 16'h0F00 + 16'(i * 257);
        p   = (i % 5) != 4;
        gr  = ib[3] ^ ib[1];
        return {8'h40 + ib, gr, ib[2], 1'b0, 1'b0, ib[3:0],
                p, ib[3:2], 1'b1, ib[0], ib[4], ib[1], ib[5], blo, llo};
    endfunction

    // memory model: answers a pending read one cycle after it appears
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_req && !mem_rd_valid) begin
            fetch_cnt++;
            chk(mem_rd_addr == GDT_BASE + 32'(cur_idx * 8), "R11",
                64'(mem_rd_addr), 64'(GDT_BASE + 32'(cur_idx * 8)));
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= gen_desc((mem_rd_addr - GDT_BASE) >> 3);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_load(input logic [15:0] sel, input int seg,
                           input logic [1:0] c, input bit pe, input bit vm,
                           input logic [15:0] lim);
        int          lat;
        int          idx;
        bit          ss, fetch;
        logic [1:0]  e_vec, rpl, dpl;
        logic [63:0] d;
        string       tag;
        idx = int'(sel[15:3]);
        rpl = sel[1:0];
        ss  = (seg == SSI);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_seg = 3'(seg); cpl = c;
        prot_en = pe; v86 = vm; gdt_limit = lim;
        fetch_cnt = 0; cur_idx = idx;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end

        // expected outcome, in check priority order
        d = gen_desc(idx);
        dpl = d[46:45];
        e_vec = 2'd0; fetch = 1'b0; tag = "R12";
        if (!pe || vm) begin
            tag = "R1";
        end else if ({sel[15:3], 3'b111} > lim) begin
            e_vec = 2'd1; tag = "R2";
        end else if (ss && idx == 0) begin
            e_vec = 2'd1; tag = "R3";
        end else begin
            fetch = 1'b1;
            if (ss && (d[43] || !d[41])) begin
                e_vec = 2'd1; tag = "R4";
            end else if (ss && (rpl != c || rpl != dpl)) begin
                e_vec = 2'd1; tag = "R5";
            end else if (!ss && rpl > dpl && c > dpl) begin
                e_vec = 2'd1; tag = "R6";
            end else if (!d[47]) begin
                e_vec = ss ? 2'd2 : 2'd3; tag = "R7";
            end
        end

        chk(done && fault == (e_vec != 0) && fault_vec == e_vec, tag,
            {61'(done), fault, fault_vec}, {61'd1, e_vec != 0, e_vec});
        chk(lat == (fetch ? 2 : 1), fetch ? "R11" : tag, 64'(lat), fetch ? 64'd2 : 64'd1);
        chk(fetch_cnt == int'(fetch), fetch ? "R11" : tag, 64'(fetch_cnt), 64'(fetch));

        if (!pe || vm) begin
            m_sel[seg]  = sel;
            m_base[seg] = {12'h000, sel, 4'h0};
        end else if (e_vec == 2'd0) begin
            m_sel[seg]   = sel;
            m_base[seg]  = {d[63:56], d[39:16]};
            m_limit[seg] = d[55] ? {d[51:48], d[15:0], 12'hFFF}
                                 : {12'h000, d[51:48], d[15:0]};
            m_attr[seg]  = {d[55], d[54], d[47], d[46:45], d[44], d[43], d[42], d[41], d[40]};
        end

        rd_idx = 3'(seg);
        #1;
        if (e_vec != 0) begin
            chk(rd_sel == m_sel[seg] && rd_base == m_base[seg] &&
                rd_limit == m_limit[seg] && rd_attr == m_attr[seg], "R8",
                {rd_sel, rd_base, 6'h0, rd_attr}, {m_sel[seg], m_base[seg], 6'h0, m_attr[seg]});
        end else begin
            chk(rd_sel == m_sel[seg], (!pe || vm) ? "R1" : "R9", 64'(rd_sel), 64'(m_sel[seg]));
            chk(rd_base == m_base[seg], (!pe || vm) ? "R1" : "R9", 64'(rd_base), 64'(m_base[seg]));
            chk(rd_limit == m_limit[seg], (!pe || vm) ? "R1" : "R10", 64'(rd_limit), 64'(m_limit[seg]));
            chk(rd_attr == m_attr[seg], (!pe || vm) ? "R1" : "R13", 64'(rd_attr), 64'(m_attr[seg]));
        end
    endtask

    initial begin
        for (int s = 0; s < NSEG; s++) begin
            m_sel[s] = '0; m_base[s] = '0;
            m_limit[s] = 32'h0000_FFFF; m_attr[s] = 10'h082;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state of every entry and of the handshake
        chk(req_ready && !done && !fault && !mem_rd_req, "R13",
            {60'h0, req_ready, done, fault, mem_rd_req}, 64'h8);
        for (int s = 0; s < NSEG; s++) begin
            rd_idx = 3'(s);
            #1;
            chk(rd_sel == 16'h0 && rd_base == 32'h0 && rd_limit == 32'hFFFF &&
                rd_attr == 10'h082, "R13", {rd_sel, rd_base[15:0], rd_limit[15:0], 6'h0, rd_attr},
                {16'h0, 16'h0, 16'hFFFF, 16'h082});
        end

        // protected-mode sweep: every entry, index, privilege pairing
        for (int s = 0; s < NSEG; s++) begin
            for (int i = 0; i < 45; i++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int r = 0; r < 4; r++) begin
                        do_load({13'(i), 1'b0, 2'(r)}, s, 2'(c), 1'b1, 1'b0, 16'd319);
                    end
                end
            end
        end

        // R1: shift-by-four loads keep previously loaded limit and attributes
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < NSEG; s++) begin
                for (int k = 0; k < 8; k++) begin
                    do_load(16'(k * 16'h1357 + s * 16'h0101 + m), s, 2'(k), m != 0, m != 1, 16'd319);
                end
            end
        end

        // R2: a table limit that covers only part of the last descriptor
        for (int i = 36; i < 40; i++) begin
            do_load({13'(i), 3'b000}, 3, 2'd0, 1'b1, 1'b0, 16'd317);
            do_load({13'(i), 3'b000}, 3, 2'd0, 1'b1, 1'b0, 16'd319);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule